// File: doc/BRIEF.md
# Register Rename Stage with Zero-Constant Move Elimination

This block renames a window of up to `W` integer macro-ops per cycle. It keeps a table that binds each architectural register x1..x(NARCH-1) to a physical register, and a pool of free physical registers. Every source is turned into a physical name. Every destination either gets a fresh physical register from the pool or is bound to an existing one. A source whose architectural register was written by an older op in the same window takes its name from the youngest such op, not from the table.

The block also tracks, for each architectural register, whether it is currently bound to physical register 0, which always holds zero. With this knowledge some integer ops can be finished during rename, without a physical register and without going to the scheduler. An add, OR or XOR with a zero operand, a subtract of zero, a subtract or XOR of a register with itself, an AND with zero, and a left shift by zero or of zero all reduce to a move. The op's destination is then bound to the surviving physical source, or to physical register 0. Such ops are flagged non-scheduled.

The window enters through a valid/ready pair. `win_valid` offers the whole window and `win_ready` accepts it. The stage drops `win_ready` when the free pool cannot cover every allocating op of the window. In that case nothing in the window takes effect, and the same window must be held until `win_ready` rises. The renamed outputs are combinational and are meaningful in a cycle where `win_valid && win_ready`. Physical registers are returned to the pool through `free_valid`/`free_idx`, and become allocatable from the next cycle.

Top module: `rename_zero_elim`

## Requirements
- R1: After reset every architectural register is bound to physical register 0, all `zero_bits` read 1, the pool holds physical registers 1..NPHYS-1, and `win_ready` is 1.
- R2: Allocating ops take free physical registers lowest index first, in slot order, and never physical register 0. A register returned through `free_valid`/`free_idx` can be allocated from the next cycle on. A return of index 0 is ignored.
- R3: A source naming x0 resolves to physical register 0. A destination x0 never changes the table, and a scheduled op with destination x0 allocates nothing and reports `out_pd` = 0.
- R4: A source not written by an older valid slot of the window resolves to the table's current binding.
- R5: A source written by an older valid slot of the same window takes that slot's `out_pd`, using the youngest such slot. When that producer is non-scheduled, this is the physical source it resolved to.
- R6: Op codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 shift-left, 6 and 7 other. For add, OR and XOR, a zero second operand gives a move of the first operand, and a zero first operand with a register second operand gives a move of the second. For shift-left, a zero shift amount gives a move of the first operand, and a zero first operand gives zero. An operand is zero when its physical name is 0, or, for an immediate second operand (`slot_use_imm` = 1), when `slot_imm_zero` is 1.
- R7: Subtract with a zero second operand gives a move of the first operand. Subtract, or XOR, whose two register operands have the same physical name gives zero (physical register 0).
- R8: AND with either operand zero gives zero. Any eliminable op with both operands zero gives zero (a no-op binding to physical register 0).
- R9: An eliminated op raises `out_nonsched`, allocates nothing and binds its destination to its resolved result. A scheduled op (including codes 6 and 7, which are never eliminated) binds its destination to its newly allocated register.
- R10: When the window's allocating ops outnumber the free registers, `win_ready` is 0 and neither the table nor the pool changes from the window. With `win_valid` low, `win_ready` is 1.
- R11: `zero_bits[a]` is 1 exactly when architectural register a is bound to physical register 0, and it follows every table write from the next cycle. Bit 0 is always 1.
- R12: When several slots of an accepted window write the same destination, the youngest slot's binding is the one kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | Window offered |
| win_ready | output | 1 | Window accepted this cycle |
| slot_valid | input | W | Per-slot op present |
| slot_op | input | W*3 | Per-slot op code (R6) |
| slot_rs1 | input | W*AW | First architectural source |
| slot_rs2 | input | W*AW | Second architectural source (unused when immediate) |
| slot_rd | input | W*AW | Architectural destination |
| slot_use_imm | input | W | Second operand is an immediate |
| slot_imm_zero | input | W | The immediate is zero |
| free_valid | input | W | Return request per port |
| free_idx | input | W*PW | Physical register returned |
| out_ps1 | output | W*PW | Renamed first source |
| out_ps2 | output | W*PW | Renamed second source |
| out_pd | output | W*PW | Destination binding (allocated or resolved) |
| out_nonsched | output | W | Op finished in rename |
| zero_bits | output | NARCH | Per-architectural-register zero binding |

## Verification
The case that matters most is when elimination and same-window forwarding happen in one cycle. A younger slot reads a register that an older slot of the same window has just reduced to a move. It must pick up the older slot's resolved source, and may itself be eliminated as a result. Directed windows chain a self-subtract, a move through OR and an add of the two, and compare the expected physical names with the outputs. A second overlap is a stall while a register is being returned: the stalled window is checked to stay out on that cycle and to get the returned register one cycle later. A behavioural model using a working copy of the table then checks long random windows cycle by cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_SUB   = 3'd1,
    OP_AND   = 3'd2,
    OP_OR    = 3'd3,
    OP_XOR   = 3'd4,
    OP_SLL   = 3'd5,
    OP_OTHER = 3'd6
  } op_e;
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
  parameter int NPHYS = 32,
  parameter int W     = 4,
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [W-1:0]         port_valid,
  output logic [W-1:0][PW-1:0] port_idx,
  input  logic [W-1:0]         port_alloc,
  input  logic [W-1:0]         free_valid,
  input  logic [W-1:0][PW-1:0] free_idx
);
  logic [NPHYS-1:0] avail_q, avail_d;

  // offer the lowest free indices, one per port, in port order
  always_comb begin
    int n;
    n = 0;
    port_valid = '0;
    port_idx   = '0;
    for (int r = 1; r < NPHYS; r++) begin
      if (avail_q[r]) begin
        for (int k = 0; k < W; k++) begin
          if (k == n) begin
            port_valid[k] = 1'b1;
            port_idx[k]   = PW'(r);
          end
        end
        n++;
      end
    end
  end

  always_comb begin
    avail_d = avail_q;
    for (int k = 0; k < W; k++)
      if (port_alloc[k]) avail_d[port_idx[k]] = 1'b0;
    for (int k = 0; k < W; k++)
      if (free_valid[k]) avail_d[free_idx[k]] = 1'b1;
    avail_d[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) avail_q <= {{(NPHYS-1){1'b1}}, 1'b0};
    else        avail_q <= avail_d;
  end
endmodule

// File: rtl/rn_map.sv
module rn_map #(
  parameter int NARCH = 32,
  parameter int NPHYS = 32,
  parameter int W     = 4,
  localparam int AW   = $clog2(NARCH),
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*W-1:0][AW-1:0] rd_arch,
  output logic [2*W-1:0][PW-1:0] rd_phys,
  input  logic [W-1:0]           wr_en,
  input  logic [W-1:0][AW-1:0]   wr_arch,
  input  logic [W-1:0][PW-1:0]   wr_phys,
  output logic [NARCH-1:0]       zero_bits
);
  logic [PW-1:0]    bind_q [NARCH];
  logic [NARCH-1:0] zero_q;

  for (genvar g = 0; g < 2*W; g++) begin : g_rd
    assign rd_phys[g] = (rd_arch[g] == '0) ? '0 : bind_q[rd_arch[g]];
  end

  // later ports overwrite earlier ones: youngest slot wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int a = 0; a < NARCH; a++) bind_q[a] <= '0;
      zero_q <= '1;
    end else begin
      for (int k = 0; k < W; k++) begin
        if (wr_en[k] && wr_arch[k] != '0) begin
          bind_q[wr_arch[k]] <= wr_phys[k];
          zero_q[wr_arch[k]] <= (wr_phys[k] == '0);
        end
      end
    end
  end

  assign zero_bits = zero_q;
endmodule

// File: rtl/rn_window.sv
module rn_window
  import rn_pkg::*;
#(
  parameter int W  = 4,
  parameter int AW = 5,
  parameter int PW = 5
) (
  input  logic                   win_valid,
  output logic                   win_ready,
  input  logic [W-1:0]           slot_valid,
  input  logic [W-1:0][2:0]      slot_op,
  input  logic [W-1:0][AW-1:0]   slot_rs1,
  input  logic [W-1:0][AW-1:0]   slot_rs2,
  input  logic [W-1:0][AW-1:0]   slot_rd,
  input  logic [W-1:0]           slot_use_imm,
  input  logic [W-1:0]           slot_imm_zero,
  input  logic [2*W-1:0][PW-1:0] map_phys,
  input  logic [W-1:0]           fl_valid,
  input  logic [W-1:0][PW-1:0]   fl_idx,
  output logic [W-1:0]           fl_alloc,
  output logic [W-1:0]           wr_en,
  output logic [W-1:0][AW-1:0]   wr_arch,
  output logic [W-1:0][PW-1:0]   wr_phys,
  output logic [W-1:0][PW-1:0]   ps1,
  output logic [W-1:0][PW-1:0]   ps2,
  output logic [W-1:0][PW-1:0]   pd,
  output logic [W-1:0]           nonsched
);
  // returns {eliminated, resulting physical name}
  function automatic logic [PW:0] reduce(input logic [2:0] op, input logic imm,
                                          input logic za, input logic zb,
                                          input logic [PW-1:0] pa, input logic [PW-1:0] pb);
    logic twin;
    twin = !imm && (pa == pb);
    reduce = '0;
    case (op)
      OP_ADD, OP_OR, OP_XOR: begin
        if (zb)               reduce = {1'b1, pa};
        else if (za && !imm)  reduce = {1'b1, pb};
        else if (op == OP_XOR && twin) reduce = {1'b1, {PW{1'b0}}};
      end
      OP_SUB: begin
        if (zb)        reduce = {1'b1, pa};
        else if (twin) reduce = {1'b1, {PW{1'b0}}};
      end
      OP_AND:  if (za || zb) reduce = {1'b1, {PW{1'b0}}};
      OP_SLL: begin
        if (zb)      reduce = {1'b1, pa};
        else if (za) reduce = {1'b1, {PW{1'b0}}};
      end
      default: reduce = '0;
    endcase
  endfunction

  logic [W-1:0] alloc_raw, wr_raw;
  logic         short_fl;

  // serial walk: each slot sees the final bindings of every older slot
  always_comb begin
    int na;
    logic [PW-1:0] s1, s2, pick;
    logic          vld, need, pick_ok;
    logic [PW:0]   red;
    na = 0;
    short_fl = 1'b0;
    alloc_raw = '0;
    wr_raw = '0;
    ps1 = '0; ps2 = '0; pd = '0; nonsched = '0;
    wr_arch = '0;
    for (int i = 0; i < W; i++) begin
      vld = win_valid && slot_valid[i];
      s1 = map_phys[2*i];
      s2 = map_phys[2*i+1];
      for (int j = 0; j < i; j++) begin
        if (win_valid && slot_valid[j] && slot_rd[j] != '0) begin
          if (slot_rd[j] == slot_rs1[i]) s1 = pd[j];
          if (slot_rd[j] == slot_rs2[i]) s2 = pd[j];
        end
      end
      red = reduce(slot_op[i], slot_use_imm[i], (s1 == '0),
                   slot_use_imm[i] ? slot_imm_zero[i] : (s2 == '0), s1, s2);
      need = vld && !red[PW] && slot_rd[i] != '0;
      pick = '0;
      pick_ok = 1'b0;
      for (int k = 0; k < W; k++) begin
        if (k == na) begin
          pick    = fl_idx[k];
          pick_ok = fl_valid[k];
          if (need) alloc_raw[k] = 1'b1;
        end
      end
      if (need) begin
        if (!pick_ok) short_fl = 1'b1;
        na++;
      end
      ps1[i]      = s1;
      ps2[i]      = s2;
      nonsched[i] = vld && red[PW];
      pd[i]       = need ? pick : (red[PW] ? red[PW-1:0] : '0);
      wr_arch[i]  = slot_rd[i];
      wr_raw[i]   = vld && slot_rd[i] != '0;
    end
  end

  assign win_ready = !short_fl;
  assign fl_alloc  = alloc_raw & {W{!short_fl}};
  assign wr_en     = wr_raw & {W{!short_fl}};
  assign wr_phys   = pd;
endmodule

// File: rtl/rename_zero_elim.sv
module rename_zero_elim #(
  parameter int W     = 4,
  parameter int NARCH = 32,
  parameter int NPHYS = 32,
  localparam int AW   = $clog2(NARCH),
  localparam int PW   = $clog2(NPHYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 win_valid,
  output logic                 win_ready,
  input  logic [W-1:0]         slot_valid,
  input  logic [W-1:0][2:0]    slot_op,
  input  logic [W-1:0][AW-1:0] slot_rs1,
  input  logic [W-1:0][AW-1:0] slot_rs2,
  input  logic [W-1:0][AW-1:0] slot_rd,
  input  logic [W-1:0]         slot_use_imm,
  input  logic [W-1:0]         slot_imm_zero,
  input  logic [W-1:0]         free_valid,
  input  logic [W-1:0][PW-1:0] free_idx,
  output logic [W-1:0][PW-1:0] out_ps1,
  output logic [W-1:0][PW-1:0] out_ps2,
  output logic [W-1:0][PW-1:0] out_pd,
  output logic [W-1:0]         out_nonsched,
  output logic [NARCH-1:0]     zero_bits
);
  logic [2*W-1:0][AW-1:0] rd_arch;
  logic [2*W-1:0][PW-1:0] rd_phys;
  logic [W-1:0]           fl_valid, fl_alloc, wr_en;
  logic [W-1:0][PW-1:0]   fl_idx, wr_phys;
  logic [W-1:0][AW-1:0]   wr_arch;

  for (genvar g = 0; g < W; g++) begin : g_rdport
    assign rd_arch[2*g]   = slot_rs1[g];
    assign rd_arch[2*g+1] = slot_rs2[g];
  end

  rn_freelist #(.NPHYS(NPHYS), .W(W)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .port_valid(fl_valid), .port_idx(fl_idx), .port_alloc(fl_alloc),
    .free_valid(free_valid), .free_idx(free_idx)
  );

  rn_map #(.NARCH(NARCH), .NPHYS(NPHYS), .W(W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_arch(rd_arch), .rd_phys(rd_phys),
    .wr_en(wr_en), .wr_arch(wr_arch), .wr_phys(wr_phys),
    .zero_bits(zero_bits)
  );

  rn_window #(.W(W), .AW(AW), .PW(PW)) u_win (
    .win_valid(win_valid), .win_ready(win_ready),
    .slot_valid(slot_valid), .slot_op(slot_op),
    .slot_rs1(slot_rs1), .slot_rs2(slot_rs2), .slot_rd(slot_rd),
    .slot_use_imm(slot_use_imm), .slot_imm_zero(slot_imm_zero),
    .map_phys(rd_phys),
    .fl_valid(fl_valid), .fl_idx(fl_idx), .fl_alloc(fl_alloc),
    .wr_en(wr_en), .wr_arch(wr_arch), .wr_phys(wr_phys),
    .ps1(out_ps1), .ps2(out_ps2), .pd(out_pd), .nonsched(out_nonsched)
  );
endmodule

// File: rtl/rename_zero_elim_chk.sv
module rename_zero_elim_chk #(
  parameter int W     = 4,
  parameter int NARCH = 32,
  parameter int NPHYS = 32,
  localparam int AW   = $clog2(NARCH),
  localparam int PW   = $clog2(NPHYS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 win_valid,
  input logic                 win_ready,
  input logic [W-1:0]         slot_valid,
  input logic [W-1:0][2:0]    slot_op,
  input logic [W-1:0][AW-1:0] slot_rs1,
  input logic [W-1:0][AW-1:0] slot_rd,
  input logic [W-1:0][PW-1:0] out_ps1,
  input logic [W-1:0][PW-1:0] out_pd,
  input logic [W-1:0]         out_nonsched,
  input logic [NARCH-1:0]     zero_bits
);
  assert_reset_all_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&zero_bits)) else $error("R1 zero bits after reset");

  assert_x0_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    zero_bits[0]) else $error("R11 x0 zero bit");

  assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid |-> win_ready) else $error("R10 idle not ready");

  assert_stall_holds_table_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !win_ready) |=> $stable(zero_bits)) else $error("R10 table changed on stall");

  for (genvar g = 0; g < W; g++) begin : g_slot
    assert_x0_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && slot_valid[g] && slot_rs1[g] == '0) |-> (out_ps1[g] == '0))
      else $error("R3 x0 source");

    assert_never_p0_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && win_ready && slot_valid[g] && !out_nonsched[g] && slot_rd[g] != '0)
        |-> (out_pd[g] != '0)) else $error("R2 scheduled op got p0");

    assert_and_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (win_valid && slot_valid[g] && slot_op[g] == 3'd2 && slot_rs1[g] == '0)
        |-> (out_nonsched[g] && out_pd[g] == '0)) else $error("R8 AND with x0");

    assert_other_scheduled_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_op[g] >= 3'd6) |-> !out_nonsched[g]) else $error("R9 other op eliminated");
  end
endmodule

bind rename_zero_elim rename_zero_elim_chk #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
  .slot_valid(slot_valid), .slot_op(slot_op), .slot_rs1(slot_rs1), .slot_rd(slot_rd),
  .out_ps1(out_ps1), .out_pd(out_pd), .out_nonsched(out_nonsched), .zero_bits(zero_bits)
);

// File: tb/rename_zero_elim_tb.sv
`timescale 1ns/1ps
module rename_zero_elim_tb;
  localparam int W = 4, NARCH = 32, NPHYS = 32;
  localparam int AW = $clog2(NARCH), PW = $clog2(NPHYS);

  logic clk = 1'b0, rst_n = 1'b0, win_valid = 1'b0, win_ready;
  logic [W-1:0] slot_valid = '0, slot_use_imm = '0, slot_imm_zero = '0, free_valid = '0;
  logic [W-1:0][2:0] slot_op = '0;
  logic [W-1:0][AW-1:0] slot_rs1 = '0, slot_rs2 = '0, slot_rd = '0;
  logic [W-1:0][PW-1:0] free_idx = '0, out_ps1, out_ps2, out_pd;
  logic [W-1:0] out_nonsched;
  logic [NARCH-1:0] zero_bits;

  int checks = 0, failures = 0;
  string tag = "R4";
  int mp[NARCH];
  bit fr[NPHYS];

  always #2.5 clk = ~clk;

  rename_zero_elim #(.W(W), .NARCH(NARCH), .NPHYS(NPHYS)) u_dut (.*);

  task automatic chk(string t, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic void m_reduce(int op, bit ui, bit za, bit zb, int pa, int pb,
                                   output bit e, output int r);
    e = 0; r = 0;
    case (op)
      0, 3, 4: if (zb) begin e = 1; r = pa; end
               else if (za && !ui) begin e = 1; r = pb; end
               else if (op == 4 && !ui && pa == pb) begin e = 1; r = 0; end
      1: if (zb) begin e = 1; r = pa; end
         else if (!ui && pa == pb) begin e = 1; r = 0; end
      2: if (za || zb) begin e = 1; r = 0; end
      5: if (zb) begin e = 1; r = pa; end
         else if (za) begin e = 1; r = 0; end
      default: e = 0;
    endcase
  endfunction

  // reference model: working copy of the table, walked slot by slot
  task automatic model_check();
    int wm[NARCH];
    int av[$];
    int na, p1, p2, d, r;
    bit shrt, e, za, zb;
    logic [NARCH-1:0] ez;
    wm = mp;
    na = 0; shrt = 0;
    for (int q = 1; q < NPHYS; q++) if (fr[q] && av.size() < W) av.push_back(q);
    for (int a = 0; a < NARCH; a++) ez[a] = (mp[a] == 0);
    chk("R11", "zero_bits", zero_bits, ez);
    for (int i = 0; i < W; i++) begin
      if (!(win_valid && slot_valid[i])) continue;
      p1 = wm[slot_rs1[i]]; p2 = wm[slot_rs2[i]];
      za = (p1 == 0); zb = slot_use_imm[i] ? slot_imm_zero[i] : (p2 == 0);
      m_reduce(slot_op[i], slot_use_imm[i], za, zb, p1, p2, e, r);
      d = 0;
      if (e) d = r;
      else if (slot_rd[i] != 0) begin
        if (na < av.size()) d = av[na]; else shrt = 1;
        na++;
      end
      if (slot_rd[i] != 0) wm[slot_rd[i]] = d;
      if (!shrt) begin
        chk(tag, $sformatf("slot%0d ps1", i), out_ps1[i], p1);
        if (!slot_use_imm[i]) chk(tag, $sformatf("slot%0d ps2", i), out_ps2[i], p2);
        chk(tag, $sformatf("slot%0d pd", i), out_pd[i], d);
        chk(tag, $sformatf("slot%0d nonsched", i), out_nonsched[i], e);
      end
    end
    chk("R10", "win_ready", win_ready, !shrt);
    if (win_valid && !shrt) begin
      mp = wm;
      for (int k = 0; k < na; k++) fr[av[k]] = 0;
    end
    for (int k = 0; k < W; k++) if (free_valid[k] && free_idx[k] != 0) fr[free_idx[k]] = 1;
  endtask

  task automatic settle(); #1; model_check(); endtask
  task automatic adv(); @(negedge clk); endtask

  task automatic clr();
    win_valid = 0; slot_valid = '0; free_valid = '0;
    slot_use_imm = '0; slot_imm_zero = '0;
  endtask

  task automatic put(int i, int op, int a, int b, int d, bit ui, bit iz);
    slot_valid[i] = 1; slot_op[i] = 3'(op);
    slot_rs1[i] = AW'(a); slot_rs2[i] = AW'(b); slot_rd[i] = AW'(d);
    slot_use_imm[i] = ui; slot_imm_zero[i] = iz;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int a = 0; a < NARCH; a++) mp[a] = 0;
    for (int q = 0; q < NPHYS; q++) fr[q] = (q != 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    clr(); tag = "R1"; settle();
    chk("R1", "zero_bits all set", zero_bits, {NARCH{1'b1}});
    chk("R1", "ready at reset", win_ready, 1);
    adv();
    // R5 R7 R6 R4: elimination chained through forwarding in one window
    clr(); win_valid = 1; tag = "R5";
    put(0, 0, 0, 0, 1, 1, 0);   // add x1 = x0 + imm -> allocates p1
    put(1, 1, 1, 1, 2, 0, 0);   // sub x2 = x1 - x1 -> zero (R7)
    put(2, 3, 1, 0, 3, 0, 0);   // or  x3 = x1 | x0 -> move p1 (R6)
    put(3, 0, 3, 2, 4, 0, 0);   // add x4 = x3 + x2 -> move of forwarded p1 (R5)
    settle();
    chk("R2", "first alloc", out_pd[0], 1);
    chk("R7", "self subtract", out_pd[1], 0);
    chk("R6", "or with x0", out_pd[2], 1);
    chk("R5", "forward from eliminated", out_pd[3], 1);
    chk("R9", "eliminated flags", out_nonsched, 4'b1110);
    adv();
    clr(); win_valid = 1; tag = "R8";
    put(0, 2, 1, 2, 5, 0, 0);   // and with zero-bound x2
    put(1, 4, 1, 1, 6, 0, 0);   // xor self
    put(2, 5, 1, 0, 7, 1, 1);   // shift by zero immediate
    put(3, 5, 0, 1, 8, 0, 0);   // shift of zero
    settle();
    chk("R11", "x2 bound to zero", zero_bits[2], 1);
    chk("R11", "x3 not zero", zero_bits[3], 0);
    chk("R4", "x1 from table", out_ps1[0], 1);
    chk("R8", "and with zero", out_pd[0], 0);
    chk("R7", "xor self", out_pd[1], 0);
    chk("R6", "shift by zero", out_pd[2], 1);
    chk("R6", "shift of zero", out_pd[3], 0);
    adv();
    clr(); win_valid = 1; tag = "R12";
    put(0, 6, 1, 4, 9, 0, 0);   // other -> p2
    put(1, 7, 0, 0, 0, 0, 0);   // other with rd x0
    put(2, 0, 1, 0, 1, 1, 0);   // add x1 = x1 + imm -> p3
    put(3, 0, 0, 0, 1, 0, 0);   // add x1 = x0 + x0 -> no-op zero
    settle();
    chk("R9", "other allocates", out_pd[0], 2);
    chk("R3", "x0 source", out_ps1[1], 0);
    chk("R3", "rd x0 no alloc", out_pd[1], 0);
    chk("R2", "skips consumed", out_pd[2], 3);
    chk("R8", "both zero no-op", out_pd[3], 0);
    adv();
    clr(); win_valid = 1; tag = "R9";
    put(0, 6, 1, 1, 10, 0, 0);
    settle();
    chk("R12", "youngest writer kept", zero_bits[1], 1);
    chk("R9", "elimination kept pool", out_pd[0], 4);
    adv();
    // R10: drain the pool, then stall with a return in flight
    tag = "R10";
    for (int w = 0; w < 6; w++) begin
      clr(); win_valid = 1;
      for (int s = 0; s < W; s++) put(s, 6, 1, 1, 11 + s, 0, 0);
      settle(); adv();
    end
    clr(); win_valid = 1;
    for (int s = 0; s < W; s++) put(s, 6, 1, 1, 11 + s, 0, 0);
    settle(); chk("R10", "stall when short", win_ready, 0); adv();
    free_valid = 4'b0011; free_idx[0] = 5'd2; free_idx[1] = 5'd0;
    settle(); chk("R2", "return not yet visible", win_ready, 0); adv();
    free_valid = '0;
    settle();
    chk("R2", "returned reg reused", out_pd[0], 2);
    chk("R2", "remaining order", out_pd[3], 31);
    adv();
    // refill the pool
    for (int c = 0; c < 8; c++) begin
      clr();
      for (int k = 0; k < W; k++) begin
        free_valid[k] = 1; free_idx[k] = PW'(c * W + k);
      end
      settle(); adv();
    end
    // random windows compared against the model every cycle
    tag = "R5";
    for (int c = 0; c < 3000; c++) begin
      clr();
      win_valid = ($urandom % 4) != 0;
      for (int s = 0; s < W; s++)
        if ($urandom % 4 != 0)
          put(s, $urandom % 8, $urandom % 6, $urandom % 6, $urandom % 8,
              $urandom % 3 == 0, $urandom % 2);
      for (int k = 0; k < W; k++)
        if ($urandom % 3 == 0) begin
          free_valid[k] = 1; free_idx[k] = PW'($urandom % NPHYS);
        end
      settle(); adv();
    end
    finish_run();
  end
endmodule